// File: doc/BRIEF.md
# Pointer Data Address Generator

This block forms the byte address for every data-memory load and store of a small 8-bit Harvard-style controller. Three 16-bit pointer registers are held inside it. Two of them are full pointers; the third (the light pointer) is reduced and has no offset mode. An access names a pointer and an addressing mode. The modes are a plain pointer read, a read with increment after use, a read with decrement before use, and a read with a short unsigned offset. The block writes the updated pointer back to itself and reports that update on a write-back port. A copy loop can therefore step a source pointer and a destination pointer together without reloading either one.

A fifth mode takes an absolute 16-bit address from the second word of a two-word instruction. On the first word the block raises a request for the second word. It issues the address once that word arrives. Pointers can be loaded through a synchronous write port. All results are registered and appear one cycle after the edge that samples the request.

Top module: `ptr_agu`

## Requirements
- R1: After reset, `addr_valid`, `err`, `need_word2` and `wb_valid` are low and all three pointers read as 0x0000.
- R2: With `ld_en` high, pointer `ld_sel` takes `ld_data` at the next edge. `ld_sel` = 3 changes no pointer.
- R3: Mode 0 (plain) issues the selected pointer on `addr` with `addr_valid` one cycle after the request. The pointer is unchanged and `wb_valid` stays low.
- R4: Mode 1 (post-increment) issues the old pointer value and writes back pointer+1. 0xFFFF wraps to 0x0000.
- R5: Mode 2 (pre-decrement) issues pointer-1 and writes that value back. 0x0000 wraps to 0xFFFF.
- R6: Mode 3 (offset) on select 1 or 2 issues pointer + the 6-bit unsigned `op_disp` (0 to 63), modulo 2^16, and leaves the pointer unchanged.
- R7: Mode 3 on select 0 (the light pointer) raises `err` for one cycle. It issues no address and changes no pointer.
- R8: Select 3 with modes 0 to 3, and any mode code 5 to 7, raise `err`, issue no address and change no pointer.
- R9: Mode 4 (direct) raises `need_word2` from the next cycle until `word2_valid` is seen. `addr` equals `op_word2` one cycle after that sample. Requests made while `need_word2` is high are ignored.
- R10: When a load and a pointer update hit the same pointer in one cycle, the loaded value wins.
- R11: `wb_valid`, `wb_sel` and `wb_value` report each pointer update in the same cycle as its address. `err` and `addr_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Access request this cycle |
| op_mode | input | 3 | 0 plain, 1 post-inc, 2 pre-dec, 3 offset, 4 direct |
| op_sel | input | 2 | Pointer select: 0 light, 1 and 2 full, 3 illegal |
| op_disp | input | 6 | Unsigned offset for mode 3 |
| word2_valid | input | 1 | Second instruction word present |
| op_word2 | input | 16 | Absolute address from the second word |
| ld_en | input | 1 | Pointer load strobe |
| ld_sel | input | 2 | Pointer to load |
| ld_data | input | 16 | Load value |
| addr_valid | output | 1 | Address issued |
| addr | output | 16 | Effective byte address |
| err | output | 1 | Illegal request |
| need_word2 | output | 1 | Waiting for the direct-address word |
| wb_valid | output | 1 | Pointer updated |
| wb_sel | output | 2 | Updated pointer |
| wb_value | output | 16 | New pointer value |

## Verification
A corrupted pointer shows on `addr` at the next access that names it, one cycle after that request. The addresses of later post-increment and pre-decrement accesses then drift away from the model's values. A stuck or skipped direct-mode state shows within one cycle, as a wrong `need_word2` level or as `addr_valid` pulsing without a second word. The bench compares every output against a behavioural model on every cycle. A fault therefore surfaces at the first cycle where the port values differ.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;
  typedef enum logic [2:0] {
    AM_PLAIN   = 3'd0,
    AM_POSTINC = 3'd1,
    AM_PREDEC  = 3'd2,
    AM_OFFSET  = 3'd3,
    AM_DIRECT  = 3'd4
  } am_e;

  typedef enum logic {
    SQ_IDLE  = 1'b0,
    SQ_WAIT2 = 1'b1
  } sq_e;

  localparam logic [1:0] PSEL_LIGHT = 2'd0;
endpackage

// File: rtl/ptr_bank.sv
module ptr_bank #(
  parameter int AW   = 16,
  parameter int NPTR = 3,
  localparam int SW  = $clog2(NPTR + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd_en,
  input  logic [SW-1:0]            upd_sel,
  input  logic [AW-1:0]            upd_val,
  input  logic                     ld_en,
  input  logic [SW-1:0]            ld_sel,
  input  logic [AW-1:0]            ld_val,
  output logic [NPTR-1:0][AW-1:0]  ptr_q
);
  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    logic          hit_ld;
    logic          hit_upd;
    logic          en;
    logic [AW-1:0] d;

    always_comb begin
      hit_ld  = ld_en  && (ld_sel  == SW'(i));
      hit_upd = upd_en && (upd_sel == SW'(i));
      en      = hit_ld || hit_upd;
      d       = hit_ld ? ld_val : upd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ptr_q[i] <= '0;
      else if (en) ptr_q[i] <= d;
    end
  end
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ptr_agu_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DISP_W = 6,
  parameter int NPTR   = 3,
  localparam int SW    = $clog2(NPTR + 1)
) (
  input  logic [2:0]               mode,
  input  logic [SW-1:0]            sel,
  input  logic [DISP_W-1:0]        disp,
  input  logic [NPTR-1:0][AW-1:0]  ptrs,
  output logic                     ea_ok,
  output logic [AW-1:0]            ea,
  output logic                     upd_en,
  output logic [AW-1:0]            upd_val,
  output logic                     is_direct,
  output logic                     bad
);
  logic          sel_ok;
  logic [AW-1:0] cur;
  logic [AW-1:0] disp_x;

  always_comb begin
    sel_ok = (sel < SW'(NPTR));
    cur    = '0;
    for (int i = 0; i < NPTR; i++) begin
      if (sel == SW'(i)) cur = ptrs[i];
    end
    disp_x = {{(AW-DISP_W){1'b0}}, disp};
  end

  always_comb begin
    ea_ok     = 1'b0;
    ea        = cur;
    upd_en    = 1'b0;
    upd_val   = cur;
    is_direct = 1'b0;
    bad       = 1'b0;
    case (mode)
      AM_PLAIN: begin
        ea_ok = sel_ok;
      end
      AM_POSTINC: begin
        ea_ok   = sel_ok;
        upd_en  = sel_ok;
        upd_val = cur + AW'(1);
      end
      AM_PREDEC: begin
        ea_ok   = sel_ok;
        ea      = cur - AW'(1);
        upd_en  = sel_ok;
        upd_val = cur - AW'(1);
      end
      AM_OFFSET: begin
        ea_ok = sel_ok && (sel != SW'(PSEL_LIGHT));
        ea    = cur + disp_x;
      end
      AM_DIRECT: begin
        is_direct = 1'b1;
      end
      default: ;
    endcase
    bad = !ea_ok && !is_direct;
  end
endmodule

// File: rtl/dir_seq.sv
module dir_seq
  import ptr_agu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic word2_valid,
  output logic waiting,
  output logic fire
);
  sq_e st_q, st_n;

  always_comb begin
    st_n = st_q;
    fire = 1'b0;
    case (st_q)
      SQ_IDLE:  if (start) st_n = SQ_WAIT2;
      SQ_WAIT2: if (word2_valid) begin
        st_n = SQ_IDLE;
        fire = 1'b1;
      end
      default:  st_n = SQ_IDLE;
    endcase
    waiting = (st_q == SQ_WAIT2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_n;
  end
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
  import ptr_agu_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DISP_W = 6,
  parameter int NPTR   = 3,
  localparam int SW    = $clog2(NPTR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_mode,
  input  logic [SW-1:0]     op_sel,
  input  logic [DISP_W-1:0] op_disp,
  input  logic              word2_valid,
  input  logic [AW-1:0]     op_word2,
  input  logic              ld_en,
  input  logic [SW-1:0]     ld_sel,
  input  logic [AW-1:0]     ld_data,
  output logic              addr_valid,
  output logic [AW-1:0]     addr,
  output logic              err,
  output logic              need_word2,
  output logic              wb_valid,
  output logic [SW-1:0]     wb_sel,
  output logic [AW-1:0]     wb_value
);
  logic [NPTR-1:0][AW-1:0] ptrs;
  logic          ea_ok, upd_en, is_direct, bad;
  logic [AW-1:0] ea, upd_val;
  logic          waiting, fire, accept;

  logic          av_n, err_n, wbv_n;
  logic [AW-1:0] addr_n, wbval_n;
  logic [SW-1:0] wbs_n;

  ea_calc #(.AW(AW), .DISP_W(DISP_W), .NPTR(NPTR)) u_calc (
    .mode(op_mode), .sel(op_sel), .disp(op_disp), .ptrs(ptrs),
    .ea_ok(ea_ok), .ea(ea), .upd_en(upd_en), .upd_val(upd_val),
    .is_direct(is_direct), .bad(bad)
  );

  assign accept = op_valid && !waiting;

  dir_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(accept && is_direct), .word2_valid(word2_valid),
    .waiting(waiting), .fire(fire)
  );

  ptr_bank #(.AW(AW), .NPTR(NPTR)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .upd_en(accept && upd_en), .upd_sel(op_sel), .upd_val(upd_val),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_data),
    .ptr_q(ptrs)
  );

  always_comb begin
    av_n    = 1'b0;
    addr_n  = addr;
    err_n   = 1'b0;
    wbv_n   = 1'b0;
    wbs_n   = wb_sel;
    wbval_n = wb_value;
    if (fire) begin
      av_n   = 1'b1;
      addr_n = op_word2;
    end else if (accept) begin
      err_n = bad;
      if (ea_ok) begin
        av_n   = 1'b1;
        addr_n = ea;
      end
      if (upd_en) begin
        wbv_n   = 1'b1;
        wbs_n   = op_sel;
        wbval_n = upd_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr       <= '0;
      err        <= 1'b0;
      wb_valid   <= 1'b0;
      wb_sel     <= '0;
      wb_value   <= '0;
    end else begin
      addr_valid <= av_n;
      addr       <= addr_n;
      err        <= err_n;
      wb_valid   <= wbv_n;
      wb_sel     <= wbs_n;
      wb_value   <= wbval_n;
    end
  end

  assign need_word2 = waiting;
endmodule

// File: rtl/ptr_agu_chk.sv
module ptr_agu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [2:0]  op_mode,
  input logic [1:0]  op_sel,
  input logic        word2_valid,
  input logic [15:0] op_word2,
  input logic        addr_valid,
  input logic [15:0] addr,
  input logic        err,
  input logic        need_word2,
  input logic        wb_valid
);
  // R11
  a_r11_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && addr_valid));

  // R11
  a_r11_wb_with_addr: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> addr_valid);

  // R9
  a_r9_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
    need_word2 && !word2_valid |=> need_word2 && !addr_valid);

  // R9
  a_r9_issue: assert property (@(posedge clk) disable iff (!rst_n)
    need_word2 && word2_valid |=> addr_valid && !need_word2 && addr == $past(op_word2));

  // R7
  a_r7_light_offset: assert property (@(posedge clk) disable iff (!rst_n)
    !need_word2 && op_valid && op_mode == 3'd3 && op_sel == 2'd0 |=> err && !wb_valid);

  // R6
  a_r6_offset_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    !need_word2 && op_valid && op_mode == 3'd3 |=> !wb_valid);

  // R8
  a_r8_bad_sel: assert property (@(posedge clk) disable iff (!rst_n)
    !need_word2 && op_valid && op_mode < 3'd4 && op_sel == 2'd3 |=> err && !addr_valid);
endmodule

bind ptr_agu ptr_agu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
  .op_sel(op_sel), .word2_valid(word2_valid), .op_word2(op_word2),
  .addr_valid(addr_valid), .addr(addr), .err(err),
  .need_word2(need_word2), .wb_valid(wb_valid)
);

// File: tb/sim_ptr_agu.sv
module sim_ptr_agu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_mode = '0;
  logic [1:0]  op_sel = '0;
  logic [5:0]  op_disp = '0;
  logic        word2_valid = 1'b0;
  logic [15:0] op_word2 = '0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_sel = '0;
  logic [15:0] ld_data = '0;
  logic        addr_valid, err, need_word2, wb_valid;
  logic [15:0] addr, wb_value;
  logic [1:0]  wb_sel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int    p[3];
  bit    m_wait;
  bit    e_av, e_err, e_wbv;
  int    e_addr, e_wbs, e_wbval;
  string tag;

  always #2.5 clk = ~clk;

  ptr_agu u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
    .op_sel(op_sel), .op_disp(op_disp), .word2_valid(word2_valid),
    .op_word2(op_word2), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .addr_valid(addr_valid), .addr(addr), .err(err), .need_word2(need_word2),
    .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_value(wb_value)
  );

  function automatic void model();
    int s;
    e_av = 0; e_err = 0; e_wbv = 0;
    s = int'(op_sel);
    if (m_wait) begin
      if (word2_valid) begin
        e_av = 1; e_addr = int'(op_word2); m_wait = 0; tag = "R9";
      end else tag = "R9";
    end else if (op_valid) begin
      if (op_mode == 3'd4) begin
        m_wait = 1; tag = "R9";
      end else if (op_mode > 3'd4 || s == 3) begin
        e_err = 1; tag = "R8";
      end else if (op_mode == 3'd3 && s == 0) begin
        e_err = 1; tag = "R7";
      end else begin
        e_av = 1;
        case (op_mode)
          3'd0: begin e_addr = p[s]; tag = "R3"; end
          3'd1: begin e_addr = p[s]; e_wbv = 1; e_wbs = s;
                      e_wbval = (p[s] + 1) & 16'hFFFF; p[s] = e_wbval; tag = "R4"; end
          3'd2: begin e_addr = (p[s] - 1) & 16'hFFFF; e_wbv = 1; e_wbs = s;
                      e_wbval = e_addr; p[s] = e_wbval; tag = "R5"; end
          default: begin e_addr = (p[s] + int'(op_disp)) & 16'hFFFF; tag = "R6"; end
        endcase
      end
    end else tag = "R2";
    if (ld_en && ld_sel != 2'd3) begin
      p[ld_sel] = int'(ld_data);
      if (e_wbv && e_wbs == int'(ld_sel)) tag = "R10";
    end
  endfunction

  task automatic compare();
    checks++;
    if (addr_valid !== e_av || err !== e_err || need_word2 !== m_wait ||
        wb_valid !== e_wbv ||
        (e_av && int'(addr) != e_addr) ||
        (e_wbv && (int'(wb_sel) != e_wbs || int'(wb_value) != e_wbval))) begin
      failures++;
      $display("FAIL %s: got av=%0b addr=%h err=%0b nw=%0b wbv=%0b wbs=%0d wb=%h exp av=%0b addr=%h err=%0b nw=%0b wbv=%0b wbs=%0d wb=%h",
               tag, addr_valid, addr, err, need_word2, wb_valid, wb_sel, wb_value,
               e_av, e_addr[15:0], e_err, m_wait, e_wbv, e_wbs, e_wbval[15:0]);
    end
  endtask

  task automatic step(input bit v, input int md, input int sl, input int d,
                      input bit w2v, input int w2, input bit le, input int ls, input int ldd);
    op_valid = v; op_mode = 3'(md); op_sel = 2'(sl); op_disp = 6'(d);
    word2_valid = w2v; op_word2 = 16'(w2);
    ld_en = le; ld_sel = 2'(ls); ld_data = 16'(ldd);
    model();
    @(negedge clk);
    compare();
  endtask

  task automatic op(input int md, input int sl, input int d);
    step(1, md, sl, d, 0, 0, 0, 0, 0);
  endtask

  task automatic load(input int sl, input int val);
    step(0, 0, 0, 0, 0, 0, 1, sl, val);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) p[i] = 0;
    m_wait = 0; e_av = 0; e_err = 0; e_wbv = 0; e_addr = 0; e_wbs = 0; e_wbval = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    compare();
    // R1: pointers read zero
    for (int s = 0; s < 3; s++) op(0, s, 0);
    // R2 loads, incl. ignored select 3
    load(0, 16'h0000); load(1, 16'h1000); load(2, 16'hFFFF);
    load(3, 16'hABCD);
    for (int s = 0; s < 3; s++) op(0, s, 0);
    // R4 wrap, R5 wrap
    op(1, 2, 0); op(0, 2, 0);
    op(2, 0, 0); op(0, 0, 0);
    op(1, 1, 0); op(2, 1, 0);
    // R6 offsets, incl. wrap
    op(3, 1, 63); op(3, 1, 0);
    load(2, 16'hFFF0); op(3, 2, 63); op(0, 2, 0);
    // R7, R8
    op(3, 0, 5); op(0, 0, 0);
    op(1, 3, 0); op(5, 1, 0); op(7, 2, 0); op(0, 1, 0);
    // R9 with waiting, ignored request
    op(4, 0, 0);
    step(1, 1, 1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 1, 0, 1, 16'hBEEF, 0, 0, 0);
    op(0, 1, 0);
    // R10 collision
    step(1, 1, 1, 0, 0, 0, 1, 1, 16'h4321);
    op(0, 1, 0);
    // random mix
    for (int n = 0; n < 2000; n++) begin
      step(($urandom % 4) != 0, $urandom % 8, $urandom % 4, $urandom % 64,
           ($urandom % 2) == 1, $urandom % 65536,
           ($urandom % 6) == 0, $urandom % 4, $urandom % 65536);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule